// File: doc/BRIEF.md
# Indexed Effective-Address Generator

This block turns one indexed-mode postbyte of a 16-bit microcontroller core into an effective address. The caller pulses `start` for one cycle. In that cycle it presents the postbyte, the extension word, the four index-capable registers (X, Y, SP, PC) and the two 8-bit accumulators. The accumulators also form the 16-bit D value, with A as the high byte. All inputs are sampled only in the `start` cycle.

Direct forms finish in the next cycle. The two indirect forms first issue a 16-bit pointer read on a simple request/ready port, and the pointer returned becomes the effective address. Alongside the address the block reports four things:
- a base-register writeback, used by the auto-modify forms;
- a flag for one extra execution cycle;
- an invalid flag, raised when the restricted mode rejects the form;
- a one-cycle `done` pulse.

The caller supplies a PC value that already points past the postbyte and its extension bytes.

Top module: `idx_ea_gen`

## Requirements
- R1: When postbyte bit 5 is 0, bits 7:6 pick the base (0=X, 1=Y, 2=SP, 3=PC). Bits 4:0, read as a two's-complement value from -16 to +15, are added to the base. No writeback and no extra cycle result.
- R2: When bit 5 is 1 and bits 7:6 are not 11, the form is auto-modify on the base in bits 7:6. Bits 3:0 below 8 give a step of value+1; otherwise the step is the value minus 16. `wb_en` pulses with `done`, `wb_sel` names the base, and `wb_value` is base+step.
- R3: In the auto-modify form, bit 4 = 0 makes the effective address base+step (pre-modify). Bit 4 = 1 makes it the unmodified base (post-modify).
- R4: With bits 7:6 = 11 the base comes from bits 4:3. If bit 2 is 0 and bits 2:0 are not 011, a constant offset is added and `extra_cycle` is 1. Bit 1 = 1 adds the full 16-bit extension. Bit 1 = 0 adds the low extension byte, extended with 0xFF00 when bit 0 is 1 and zero-extended otherwise.
- R5: With bits 7:6 = 11 and bits 2:0 = 100, 101 or 110, the addend is A, B or D respectively. A and B are zero-extended. There is no extra cycle.
- R6: Two indirect forms exist, both with bits 7:6 = 11: bits 2:0 = 011 (base + 16-bit extension) and bits 2:0 = 111 (base + D). Each drives `mem_addr` with that sum and holds `mem_req` until `mem_ready`. The `mem_rdata` sampled with `mem_ready` becomes `ea`, and `extra_cycle` is 1.
- R7: With `restrict_en` high, the 011 indirect form and both constant-offset forms are rejected. `done` comes one cycle after `start` with `ea` = 0, `invalid` = 1, no writeback, no memory request and `extra_cycle` = 0. All other forms behave as without restriction.
- R8: For a direct or rejected form, `done` is high in the cycle after the `start` cycle. For an indirect form, `mem_req` is high from the cycle after `start`, and `done` comes in the cycle after `mem_ready` is sampled. A `start` while a read is pending is ignored.
- R9: All address sums wrap modulo 2^16.
- R10: After reset, `done`, `mem_req`, `wb_en` and `invalid` are 0, and `ea` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding; inputs sampled this cycle |
| restrict_en | input | 1 | Reject the long-offset and 16-bit indirect forms |
| postbyte | input | 8 | Indexed-mode postbyte |
| ext_word | input | 16 | Extension; low byte used by the 9-bit form |
| reg_x | input | 16 | X index register |
| reg_y | input | 16 | Y index register |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | PC past the operand bytes |
| acc_a | input | 8 | Accumulator A (high byte of D) |
| acc_b | input | 8 | Accumulator B (low byte of D) |
| mem_req | output | 1 | Pointer read pending |
| mem_addr | output | 16 | Pointer read address |
| mem_ready | input | 1 | Pointer read data valid |
| mem_rdata | input | 16 | Pointer read data |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| invalid | output | 1 | Form rejected under restriction |
| extra_cycle | output | 1 | Form costs one extra cycle |
| wb_en | output | 1 | Base writeback pulse |
| wb_sel | output | 2 | Base register to write back (0=X..3=PC) |
| wb_value | output | 16 | Value written back |

## Verification
The hardest situation to reach is a `start` that arrives while an indirect pointer read is still pending. Reaching it needs an indirect postbyte, a memory latency held open by the bench, and a second request injected during that wait. The bench stretches `mem_ready` over several cycles, pulses `start` with another postbyte in the middle, and then checks two things at the ports. The completed result must still be the pointer, and no second `done` may follow. Wrap-around is reached by placing base registers near 0xFFFF and 0x0000.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int AW = 16;
  localparam int BW = 8;
  localparam int BSELW = 2;

  typedef enum logic [2:0] {
    FM_K5, FM_AUTO, FM_K9, FM_K16, FM_IND16, FM_ACC, FM_DIND
  } fm_e;

  typedef struct packed {
    fm_e              fm;
    logic [BSELW-1:0] base;
    logic [1:0]       acc;
    logic             post;
    logic             wb;
    logic             extra;
    logic             indirect;
    logic             reject;
  } dec_t;

  function automatic logic [AW-1:0] sx5(input logic [4:0] v);
    return {{(AW-5){v[4]}}, v};
  endfunction

  function automatic logic [AW-1:0] step4(input logic [3:0] n);
    if (n[3]) return {{(AW-4){1'b1}}, n};
    return AW'(n) + AW'(1);
  endfunction

  function automatic logic [AW-1:0] kext9(input logic sgn, input logic [BW-1:0] lo);
    return {{(AW-BW){sgn}}, lo};
  endfunction

  function automatic dec_t decode(input logic [7:0] pb, input logic restr);
    dec_t d;
    d = '0;
    d.fm = FM_K5;
    if (!pb[5]) begin
      d.base = pb[7:6];
    end else if (pb[7:6] != 2'b11) begin
      d.fm   = FM_AUTO;
      d.base = pb[7:6];
      d.post = pb[4];
      d.wb   = 1'b1;
    end else begin
      d.base = pb[4:3];
      if (pb[2:0] == 3'b011) begin
        d.fm       = FM_IND16;
        d.indirect = 1'b1;
        d.extra    = 1'b1;
        d.reject   = restr;
      end else if (!pb[2]) begin
        d.fm     = pb[1] ? FM_K16 : FM_K9;
        d.extra  = 1'b1;
        d.reject = restr;
      end else begin
        d.acc = pb[1:0];
        if (pb[1:0] == 2'b11) begin
          d.fm       = FM_DIND;
          d.indirect = 1'b1;
          d.extra    = 1'b1;
        end else begin
          d.fm = FM_ACC;
        end
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idx_ea_pkg::*;
(
  input  logic [7:0] pb,
  input  logic       restr,
  output dec_t       dec
);
  always_comb dec = decode(pb, restr);
endmodule

// File: rtl/idx_addr_unit.sv
module idx_addr_unit
  import idx_ea_pkg::*;
(
  input  fm_e              fm,
  input  logic [BSELW-1:0] base_sel,
  input  logic [1:0]       acc_sel,
  input  logic             post,
  input  logic [4:0]       pb_lo,
  input  logic [AW-1:0]    ext,
  input  logic [AW-1:0]    rx,
  input  logic [AW-1:0]    ry,
  input  logic [AW-1:0]    rsp,
  input  logic [AW-1:0]    rpc,
  input  logic [BW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW-1:0]    sum,
  output logic [AW-1:0]    direct_ea
);
  logic [AW-1:0] base_v, addend, dval;

  assign dval = {a, b};

  always_comb begin
    case (base_sel)
      2'd0:    base_v = rx;
      2'd1:    base_v = ry;
      2'd2:    base_v = rsp;
      default: base_v = rpc;
    endcase
  end

  always_comb begin
    case (fm)
      FM_K5:            addend = sx5(pb_lo);
      FM_AUTO:          addend = step4(pb_lo[3:0]);
      FM_K9:            addend = kext9(pb_lo[0], ext[BW-1:0]);
      FM_K16, FM_IND16: addend = ext;
      FM_ACC: begin
        case (acc_sel)
          2'd0:    addend = {{(AW-BW){1'b0}}, a};
          2'd1:    addend = {{(AW-BW){1'b0}}, b};
          default: addend = dval;
        endcase
      end
      default:          addend = dval;
    endcase
  end

  assign sum       = base_v + addend;
  assign direct_ea = (fm == FM_AUTO && post) ? base_v : sum;
endmodule

// File: rtl/idx_seq.sv
module idx_seq
  import idx_ea_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             reject,
  input  logic             indirect,
  input  logic             extra,
  input  logic             wb,
  input  logic [BSELW-1:0] base_sel,
  input  logic [AW-1:0]    sum,
  input  logic [AW-1:0]    direct_ea,
  input  logic             mem_ready,
  input  logic [AW-1:0]    mem_rdata,
  output logic             accept,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic             done,
  output logic [AW-1:0]    ea,
  output logic             invalid,
  output logic             extra_cycle,
  output logic             wb_en,
  output logic [BSELW-1:0] wb_sel,
  output logic [AW-1:0]    wb_value
);
  typedef enum logic {S_IDLE, S_MEM} st_e;
  st_e st;

  assign accept  = start && (st == S_IDLE);
  assign mem_req = (st == S_MEM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      mem_addr    <= '0;
      done        <= 1'b0;
      ea          <= '0;
      invalid     <= 1'b0;
      extra_cycle <= 1'b0;
      wb_en       <= 1'b0;
      wb_sel      <= '0;
      wb_value    <= '0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (reject) begin
              done        <= 1'b1;
              ea          <= '0;
              invalid     <= 1'b1;
              extra_cycle <= 1'b0;
            end else if (indirect) begin
              st          <= S_MEM;
              mem_addr    <= sum;
              invalid     <= 1'b0;
              extra_cycle <= 1'b1;
            end else begin
              done        <= 1'b1;
              ea          <= direct_ea;
              invalid     <= 1'b0;
              extra_cycle <= extra;
              wb_en       <= wb;
              wb_sel      <= base_sel;
              wb_value    <= sum;
            end
          end
        end
        default: begin
          if (mem_ready) begin
            ea   <= mem_rdata;
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          restrict_en,
  input  logic [7:0]    postbyte,
  input  logic [15:0]   ext_word,
  input  logic [15:0]   reg_x,
  input  logic [15:0]   reg_y,
  input  logic [15:0]   reg_sp,
  input  logic [15:0]   reg_pc,
  input  logic [7:0]    acc_a,
  input  logic [7:0]    acc_b,
  output logic          mem_req,
  output logic [15:0]   mem_addr,
  input  logic          mem_ready,
  input  logic [15:0]   mem_rdata,
  output logic          done,
  output logic [15:0]   ea,
  output logic          invalid,
  output logic          extra_cycle,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [15:0]   wb_value
);
  dec_t          dec;
  logic [AW-1:0] sum, direct_ea;
  logic          accept;

  idx_decode u_dec (.pb(postbyte), .restr(restrict_en), .dec(dec));

  idx_addr_unit u_addr (
    .fm(dec.fm), .base_sel(dec.base), .acc_sel(dec.acc), .post(dec.post),
    .pb_lo(postbyte[4:0]), .ext(ext_word),
    .rx(reg_x), .ry(reg_y), .rsp(reg_sp), .rpc(reg_pc),
    .a(acc_a), .b(acc_b), .sum(sum), .direct_ea(direct_ea)
  );

  idx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .reject(dec.reject), .indirect(dec.indirect), .extra(dec.extra),
    .wb(dec.wb), .base_sel(dec.base), .sum(sum), .direct_ea(direct_ea),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .accept(accept),
    .mem_req(mem_req), .mem_addr(mem_addr), .done(done), .ea(ea),
    .invalid(invalid), .extra_cycle(extra_cycle), .wb_en(wb_en),
    .wb_sel(wb_sel), .wb_value(wb_value)
  );
endmodule

// File: rtl/idx_ea_gen_chk.sv
module idx_ea_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        mem_req,
  input logic [15:0] mem_addr,
  input logic        mem_ready,
  input logic [15:0] mem_rdata,
  input logic        done,
  input logic [15:0] ea,
  input logic        invalid,
  input logic        extra_cycle,
  input logic        wb_en
);
  AST_REQ_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !done); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R6
  AST_REQ_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> done && !mem_req && ea == $past(mem_rdata)); // R6
  AST_REJECT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done && invalid |-> ea == 16'h0 && !wb_en && !extra_cycle); // R7
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done && !invalid); // R2
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(accept) || $past(mem_req && mem_ready)); // R8
endmodule

bind idx_ea_gen idx_ea_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
  .done(done), .ea(ea), .invalid(invalid), .extra_cycle(extra_cycle),
  .wb_en(wb_en)
);

// File: tb/idx_ea_gen_test.sv
`timescale 1ns/1ps
module idx_ea_gen_test;
  logic clk = 0, rst_n = 0, start = 0, restrict_en = 0, mem_ready = 0;
  logic [7:0]  postbyte = 0, acc_a = 0, acc_b = 0;
  logic [15:0] ext_word = 0, reg_x = 0, reg_y = 0, reg_sp = 0, reg_pc = 0, mem_rdata = 0;
  logic mem_req, done, invalid, extra_cycle, wb_en;
  logic [15:0] mem_addr, ea, wb_value;
  logic [1:0] wb_sel;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  idx_ea_gen uut (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: integer arithmetic, outputs the expected results
  task automatic model(input int pb, input int ext, input bit rs,
                       output bit inv, output bit ind, output int ptr,
                       output int xea, output bit wbe, output int wsel,
                       output int wval, output bit xc);
    int regs[4];
    int bi, off, stp, b;
    regs[0] = reg_x; regs[1] = reg_y; regs[2] = reg_sp; regs[3] = reg_pc;
    inv = 0; ind = 0; ptr = 0; xea = 0; wbe = 0; wsel = 0; wval = 0; xc = 0;
    if (((pb / 32) % 2) == 0) begin
      bi = pb / 64; off = pb % 32; if (off > 15) off -= 32;
      xea = (regs[bi] + off) & 16'hFFFF;
    end else if (pb < 192) begin
      bi = pb / 64; stp = pb % 16;
      stp = (stp < 8) ? stp + 1 : stp - 16;
      wbe = 1; wsel = bi; wval = (regs[bi] + stp) & 16'hFFFF;
      xea = (((pb / 16) % 2) == 1) ? regs[bi] : wval;
    end else begin
      bi = (pb / 8) % 4; b = regs[bi];
      if ((pb % 8) == 3) begin
        if (rs) inv = 1;
        else begin ind = 1; xc = 1; ptr = (b + ext) & 16'hFFFF; end
      end else if (((pb / 4) % 2) == 0) begin
        if (rs) inv = 1;
        else begin
          if (((pb / 2) % 2) == 1) off = ext;
          else off = ((pb % 2) == 1) ? (ext % 256) - 256 : ext % 256;
          xc = 1; xea = (b + off) & 16'hFFFF;
        end
      end else begin
        case (pb % 4)
          0: xea = (b + acc_a) & 16'hFFFF;
          1: xea = (b + acc_b) & 16'hFFFF;
          2: xea = (b + acc_a * 256 + acc_b) & 16'hFFFF;
          default: begin ind = 1; xc = 1; ptr = (b + acc_a * 256 + acc_b) & 16'hFFFF; end
        endcase
      end
    end
  endtask

  // one operation, compared cycle by cycle at negedges
  task automatic run(string req, input int pb, input int ext, input bit rs,
                     input int rdata, input int lat, input bit poke);
    bit inv, ind, wbe, xc; int ptr, xea, wsel, wval;
    model(pb, ext, rs, inv, ind, ptr, xea, wbe, wsel, wval, xc);
    @(negedge clk);
    postbyte = 8'(pb); ext_word = 16'(ext); restrict_en = rs; start = 1;
    @(negedge clk);
    start = 0;
    if (ind) begin
      chk(req, "mem_req", mem_req, 1);
      chk(req, "done during read", done, 0);
      chk(req, "mem_addr", mem_addr, ptr);
      for (int i = 0; i < lat; i++) begin
        if (poke && i == 0) begin postbyte = 8'h00; start = 1; end
        @(negedge clk);
        start = 0;
        chk(req, "mem_req held", mem_req, 1);
        chk(req, "done held low", done, 0);
      end
      mem_rdata = 16'(rdata); mem_ready = 1;
      @(negedge clk);
      mem_ready = 0;
      xea = rdata;
    end
    chk(req, "done", done, 1);
    chk(req, "mem_req idle", mem_req, 0);
    chk(req, "ea", ea, xea);
    chk(req, "invalid", invalid, inv);
    chk(req, "extra_cycle", extra_cycle, xc);
    chk(req, "wb_en", wb_en, wbe);
    if (wbe) begin
      chk(req, "wb_sel", wb_sel, wsel);
      chk(req, "wb_value", wb_value, wval);
    end
    @(negedge clk);
    chk(req, "done one cycle", done, 0);
    chk(req, "no request after", mem_req, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "done", done, 0); chk("R10", "mem_req", mem_req, 0);
    chk("R10", "ea", ea, 0); chk("R10", "invalid", invalid, 0);
    chk("R10", "wb_en", wb_en, 0);
    rst_n = 1;
    reg_x = 16'h1000; reg_y = 16'h2000; reg_sp = 16'h3F00; reg_pc = 16'h8004;
    acc_a = 8'h12; acc_b = 8'hF3;
    // R1 five-bit offsets on each base
    run("R1", 'h1F, 0, 0, 0, 0, 0);
    run("R1", 'h4F, 0, 0, 0, 0, 0);
    run("R1", 'h90, 0, 0, 0, 0, 0);
    run("R1", 'hC5, 0, 0, 0, 0, 0);
    // R2 R3 auto-modify: pre/post, positive/negative steps
    run("R2", 'h20, 0, 0, 0, 0, 0);
    run("R3", 'h37, 0, 0, 0, 0, 0);
    run("R2", 'h6F, 0, 0, 0, 0, 0);
    run("R3", 'hB8, 0, 0, 0, 0, 0);
    // R4 constant offsets
    run("R4", 'hE8, 'h0077, 0, 0, 0, 0);
    run("R4", 'hE9, 'h00F0, 0, 0, 0, 0);
    run("R4", 'hF2, 'hC123, 0, 0, 0, 0);
    run("R4", 'hFA, 'h0100, 0, 0, 0, 0);
    // R5 accumulator offsets
    run("R5", 'hE4, 0, 0, 0, 0, 0);
    run("R5", 'hED, 0, 0, 0, 0, 0);
    run("R5", 'hF6, 0, 0, 0, 0, 0);
    // R6 indirect forms, with latency
    run("R6", 'hE3, 'h0040, 0, 'hBEEF, 0, 0);
    run("R6", 'hFB, 'hFFF0, 0, 'h1234, 3, 0);
    run("R6", 'hE7, 0, 0, 'h5A5A, 2, 0);
    // R8 start during pending read is ignored
    run("R8", 'hE3, 'h0002, 0, 'hCAFE, 4, 1);
    // R7 restricted mode
    run("R7", 'hE3, 'h0040, 1, 0, 0, 0);
    run("R7", 'hE0, 'h0011, 1, 0, 0, 0);
    run("R7", 'hF2, 'h1111, 1, 0, 0, 0);
    run("R7", 'h1F, 0, 1, 0, 0, 0);
    run("R7", 'h37, 0, 1, 0, 0, 0);
    run("R7", 'hE7, 0, 1, 'h0F0F, 1, 0);
    // R9 wrap-around
    reg_x = 16'hFFFE; reg_y = 16'hFFFF; reg_sp = 16'h0001;
    run("R9", 'h05, 0, 0, 0, 0, 0);
    run("R9", 'h60, 0, 0, 0, 0, 0);
    run("R9", 'hBF, 0, 0, 0, 0, 0);
    run("R9", 'hE2, 'h0010, 0, 0, 0, 0);
    run("R9", 'hE6, 0, 0, 0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule